// File: doc/BRIEF.md
# Low-Power Real-Time Clock with Deferred Register Writes

This block keeps wall-clock time in a 47-bit counter. The upper 32 bits hold whole seconds and the lower 15 bits hold the fraction of a second. The counter advances by one on every edge of a slow 32.768 kHz time base. A bus master on a fast clock reads the counter, sets a 47-bit alarm compare value and controls the counter. A status word reports alarm, validity and write progress, and a level interrupt is raised from any status flag whose enable bit is set.

The slow time base enters the block as `lp_tick`. This is a single-bus-cycle strobe that comes from an edge detector outside the block, one pulse for each slow-clock edge. Every write to a register that belongs to the slow side is held in a one-entry slot until the next strobe. The write is then applied. Completion becomes visible on the bus side `SYNC_STAGES` cycles later, which models the return synchronizer. While the slot is occupied, the block refuses any further deferred write and flags an error. The interrupt-enable word is the only register that software writes directly on the bus clock.

After reset the block reports its contents as not valid and holds the counter. Software clears the validity flags and writes the seconds word at least once. Once the run bit is set, the counter advances on every `lp_tick`.

Top module: `rtc_lp_top`

## Requirements
- R1: After reset, the registers read as follows. Seconds and fraction read 0. Alarm seconds reads 0xFFFFFFFF and alarm fraction reads 0. Control reads 0. Status reads 0x00000202 (only the idle flag at bit 9 and the not-valid flag at bit 1 are set). Interrupt enable reads 0, and `irq` is low.
- R2: The read map uses these byte offsets on `bus_addr`, and every read returns combinationally on `bus_rdata`:

  | Offset | Register |
  |---|---|
  | 0x00 | counter seconds |
  | 0x04 | counter fraction in bits 14:0 |
  | 0x08 | alarm seconds |
  | 0x0C | alarm fraction in bits 14:0 |
  | 0x10 | control, with the run bit at bit 3 |
  | 0x14 | status |
  | 0x18 | interrupt enable |
- R3: A write to offsets 0x00 to 0x14 is deferred when it finds the block idle. From the next cycle, busy (status bit 10) is set. The target register changes at the first `lp_tick` cycle after acceptance. `SYNC_STAGES` cycles later busy clears and done (status bit 8) sets at the same edge.
- R4: A deferred write that arrives while busy is set is discarded, and it sets the error flag (status bit 7) at the next edge.
- R5: A write to offset 0x18 stores the data masked to bits 9, 8, 7 and 4 at the next edge. It never sets busy or done.
- R6: Any read of the status offset (`bus_rd` high with `bus_addr` = 0x14) clears done at that edge. A completion in the same cycle keeps done set.
- R7: A deferred write to the status offset clears each of the following flags whose bit in the data is 1: alarm (bit 4), error (bit 7), not-valid (bit 1) and violation (bit 0). The clear takes effect when the write is applied. Bits that are 0 leave their flag unchanged.
- R8: The counter advances by one, wrapping at 2^47, on each `lp_tick` only while all three conditions hold:
  - the run bit is set;
  - the seconds word has been written at least once since reset;
  - not-valid is clear.

  A counter write applied on a tick replaces the increment on that tick.
- R9: Alarm (status bit 4) sets when an increment makes the counter equal to the 47-bit alarm value. This does not happen while alarm seconds is 0xFFFFFFFF.
- R10: `irq` is high exactly when one of the following pairs are both set: idle (bit 9), done (bit 8), error (bit 7) or alarm (bit 4), together with the matching enable bit.
- R11: A cycle with `tamper` high sets not-valid and violation at the next edge, which freezes the counter.
- R12: Status bit 9 (idle) is the inverse of busy.
- R13: Reads of offsets outside the map return 0. Writes to them change nothing and do not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used only for the status-read side effect |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| lp_tick | input | 1 | One-cycle strobe per slow-clock edge |
| tamper | input | 1 | Tamper event, sets the validity flags |
| irq | output | 1 | Level interrupt |

## Verification
The bench sends a deferred write right behind another one. A design that queued the second write instead of dropping it would show a changed alarm fraction and no error flag.

The bench drives the counter across its 47-bit wrap while the alarm seconds are all ones. A design that ignored the disable value would raise a false alarm at the wrap, and a carry mistake would leave the seconds non-zero.

The bench reads the counter fraction while the block is not valid, not running or tampered. A design that counted in those states would return a changed value.

A reference model that updates every cycle checks that done sets on the very edge where busy falls, and that a status read does not clear a completion arriving in the same cycle.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  localparam int DW     = 32;
  localparam int OFS_W  = 5;
  localparam int SEC_W  = 32;
  localparam int FRAC_W = 15;
  localparam int CNT_W  = SEC_W + FRAC_W;

  localparam logic [OFS_W-1:0] OFS_TSEC  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_TFRAC = 5'h04;
  localparam logic [OFS_W-1:0] OFS_ASEC  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_AFRAC = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 5'h10;
  localparam logic [OFS_W-1:0] OFS_STAT  = 5'h14;
  localparam logic [OFS_W-1:0] OFS_IEN   = 5'h18;

  localparam int CTRL_RUN  = 3;
  localparam int ST_BUSY   = 10;
  localparam int ST_IDLE   = 9;
  localparam int ST_DONE   = 8;
  localparam int ST_ERR    = 7;
  localparam int ST_ALARM  = 4;
  localparam int ST_NVAL   = 1;
  localparam int ST_VIOL   = 0;

  localparam logic [DW-1:0] IEN_MASK = (DW'(1) << ST_IDLE) | (DW'(1) << ST_DONE) |
                                       (DW'(1) << ST_ERR)  | (DW'(1) << ST_ALARM);

  // Offsets whose writes go through the slow-side slot.
  function automatic logic is_deferred(input logic [OFS_W-1:0] a);
    return (a == OFS_TSEC) || (a == OFS_TFRAC) || (a == OFS_ASEC) ||
           (a == OFS_AFRAC) || (a == OFS_CTRL) || (a == OFS_STAT);
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // An all-ones seconds field disarms the compare.
  function automatic logic alarm_armed(input logic [CNT_W-1:0] a);
    return a[CNT_W-1:FRAC_W] != {SEC_W{1'b1}};
  endfunction

  function automatic logic [DW-1:0] pack_status(input logic busy, input logic done,
                                                input logic err, input logic alarm,
                                                input logic nval, input logic viol);
    logic [DW-1:0] w;
    w = '0;
    w[ST_BUSY]  = busy;
    w[ST_IDLE]  = ~busy;
    w[ST_DONE]  = done;
    w[ST_ERR]   = err;
    w[ST_ALARM] = alarm;
    w[ST_NVAL]  = nval;
    w[ST_VIOL]  = viol;
    return w;
  endfunction
endpackage

// File: rtl/rtc_wr_sync.sv
module rtc_wr_sync
  import rtc_lp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             lp_tick_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic             reject_o,
  output logic             apply_o,
  output logic [OFS_W-1:0] apply_addr_o,
  output logic [DW-1:0]    apply_data_o,
  output logic             done_o
);
  localparam int CW = $clog2(SYNC_STAGES + 1);

  logic             busy_q, pend_q, drain_q;
  logic [CW-1:0]    dcnt_q;
  logic [OFS_W-1:0] paddr_q;
  logic [DW-1:0]    pdata_q;

  assign accept_o     = wr_i && is_deferred(addr_i) && !busy_q;
  assign reject_o     = wr_i && is_deferred(addr_i) && busy_q;
  assign apply_o      = pend_q && lp_tick_i;
  assign apply_addr_o = paddr_q;
  assign apply_data_o = pdata_q;
  assign done_o       = drain_q && (dcnt_q == CW'(1));
  assign busy_o       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      drain_q <= 1'b0;
      dcnt_q  <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      if (accept_o) begin
        pend_q  <= 1'b1;
        busy_q  <= 1'b1;
        paddr_q <= addr_i;
        pdata_q <= wdata_i;
      end
      if (apply_o) begin
        pend_q  <= 1'b0;
        drain_q <= 1'b1;
        dcnt_q  <= CW'(SYNC_STAGES);
      end else if (drain_q) begin
        dcnt_q <= dcnt_q - CW'(1);
        if (dcnt_q == CW'(1)) begin
          drain_q <= 1'b0;
          busy_q  <= 1'b0;
        end
      end
    end
  end

  // R3: an accepted write holds the slot and the busy flag
  a_r3_accept_holds: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (busy_q && pend_q));
  // R3: a pending write leaves the slot on the first tick
  a_r3_apply_drains: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |=> (!pend_q && drain_q && busy_q));
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_lp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_tick_i,
  input  logic             apply_i,
  input  logic [OFS_W-1:0] apply_addr_i,
  input  logic [DW-1:0]    apply_data_i,
  input  logic             halt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] alm_o,
  output logic             run_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, alm_q, cnt_next;
  logic             run_q, seeded_q;
  logic             cnt_wr, step_en;

  assign cnt_wr   = apply_i && ((apply_addr_i == OFS_TSEC) || (apply_addr_i == OFS_TFRAC));
  assign step_en  = lp_tick_i && run_q && seeded_q && !halt_i && !cnt_wr;
  assign cnt_next = count_step(cnt_q);
  assign hit_o    = step_en && alarm_armed(alm_q) && (cnt_next == alm_q);

  assign cnt_o = cnt_q;
  assign alm_o = alm_q;
  assign run_o = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      alm_q    <= {{SEC_W{1'b1}}, {FRAC_W{1'b0}}};
      run_q    <= 1'b0;
      seeded_q <= 1'b0;
    end else begin
      if (step_en) cnt_q <= cnt_next;
      if (apply_i) begin
        case (apply_addr_i)
          OFS_TSEC: begin
            cnt_q    <= {apply_data_i[SEC_W-1:0], cnt_q[FRAC_W-1:0]};
            seeded_q <= 1'b1;
          end
          OFS_TFRAC: cnt_q <= {cnt_q[CNT_W-1:FRAC_W], apply_data_i[FRAC_W-1:0]};
          OFS_ASEC:  alm_q <= {apply_data_i[SEC_W-1:0], alm_q[FRAC_W-1:0]};
          OFS_AFRAC: alm_q <= {alm_q[CNT_W-1:FRAC_W], apply_data_i[FRAC_W-1:0]};
          OFS_CTRL:  run_q <= apply_data_i[CTRL_RUN];
          default: ;
        endcase
      end
    end
  end

  // R8: with no step and no counter write, the counter holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !cnt_wr) |=> $stable(cnt_q));
  // R8: a step moves the counter by exactly one
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (cnt_q == count_step($past(cnt_q))));
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
  import rtc_lp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             apply_i,
  input  logic [OFS_W-1:0] apply_addr_i,
  input  logic [DW-1:0]    apply_data_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             reject_i,
  input  logic             hit_i,
  input  logic             tamper_i,
  output logic [DW-1:0]    stat_o,
  output logic [DW-1:0]    ien_o,
  output logic             irq_o
);
  logic          done_q, err_q, alarm_q, nval_q, viol_q;
  logic [DW-1:0] ien_q, clr;
  logic          stat_rd;

  assign clr     = (apply_i && (apply_addr_i == OFS_STAT)) ? apply_data_i : '0;
  assign stat_rd = rd_i && (addr_i == OFS_STAT);
  assign stat_o  = pack_status(busy_i, done_q, err_q, alarm_q, nval_q, viol_q);
  assign ien_o   = ien_q;
  assign irq_o   = |(stat_o & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      alarm_q <= 1'b0;
      nval_q  <= 1'b1;
      viol_q  <= 1'b0;
      ien_q   <= '0;
    end else begin
      if (done_i)       done_q <= 1'b1;
      else if (stat_rd) done_q <= 1'b0;
      err_q   <= (err_q   && !clr[ST_ERR])   || reject_i;
      alarm_q <= (alarm_q && !clr[ST_ALARM]) || hit_i;
      nval_q  <= (nval_q  && !clr[ST_NVAL])  || tamper_i;
      viol_q  <= (viol_q  && !clr[ST_VIOL])  || tamper_i;
      if (wr_i && (addr_i == OFS_IEN)) ien_q <= wdata_i & IEN_MASK;
    end
  end

  // R4: a refused write raises the error flag
  a_r4_err_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    reject_i |=> stat_o[ST_ERR]);
  // R6: a status read with no completion leaves done clear
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done_i) |=> !stat_o[ST_DONE]);
  // R9: a compare hit latches the alarm flag
  a_r9_alarm_latch: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> stat_o[ST_ALARM]);
  // R11: tamper marks the contents invalid
  a_r11_tamper_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_i |=> (stat_o[ST_NVAL] && stat_o[ST_VIOL]));
endmodule

// File: rtl/rtc_lp_top.sv
module rtc_lp_top
  import rtc_lp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        lp_tick,
  input  logic        tamper,
  output logic        irq
);
  logic             busy, accept, reject, apply, done, hit, run;
  logic [OFS_W-1:0] apply_addr;
  logic [DW-1:0]    apply_data, stat_word, ien_word;
  logic [CNT_W-1:0] cnt, alm;

  rtc_wr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .lp_tick_i(lp_tick), .busy_o(busy), .accept_o(accept), .reject_o(reject),
    .apply_o(apply), .apply_addr_o(apply_addr), .apply_data_o(apply_data), .done_o(done)
  );

  rtc_timebase u_time (
    .clk(clk), .rst_n(rst_n), .lp_tick_i(lp_tick), .apply_i(apply),
    .apply_addr_i(apply_addr), .apply_data_i(apply_data), .halt_i(stat_word[ST_NVAL]),
    .cnt_o(cnt), .alm_o(alm), .run_o(run), .hit_o(hit)
  );

  rtc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .apply_i(apply), .apply_addr_i(apply_addr),
    .apply_data_i(apply_data), .busy_i(busy), .done_i(done), .reject_i(reject),
    .hit_i(hit), .tamper_i(tamper), .stat_o(stat_word), .ien_o(ien_word), .irq_o(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_TSEC:  bus_rdata = cnt[CNT_W-1:FRAC_W];
      OFS_TFRAC: bus_rdata = {{(DW-FRAC_W){1'b0}}, cnt[FRAC_W-1:0]};
      OFS_ASEC:  bus_rdata = alm[CNT_W-1:FRAC_W];
      OFS_AFRAC: bus_rdata = {{(DW-FRAC_W){1'b0}}, alm[FRAC_W-1:0]};
      OFS_CTRL:  bus_rdata = DW'(run) << CTRL_RUN;
      OFS_STAT:  bus_rdata = stat_word;
      OFS_IEN:   bus_rdata = ien_word;
      default:   bus_rdata = '0;
    endcase
  end

  // R3: done appears on the same edge where busy falls
  a_r3_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> stat_word[ST_DONE]);
  // R5: an enable write on an idle block keeps it idle
  a_r5_ien_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_IEN) && !busy) |=> !busy);
  // R13: an unmapped write never occupies the slot
  a_r13_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !is_deferred(bus_addr) && !busy) |=> !busy);
  // R3: accept and refuse are exclusive
  a_r3_accept_xor_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject));
endmodule

// File: tb/rtc_lp_top_tb.sv
module rtc_lp_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam longint CMASK  = (64'd1 << 47) - 1;

  logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, lp_tick = 0, tamper = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  wire  [31:0] bus_rdata;
  wire         irq;

  int n_checks = 0, n_errors = 0, tdiv = 0, rot = 0, cycles = 0;
  bit finished = 0;

  rtc_lp_top #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lp_tick(lp_tick), .tamper(tamper),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slow-edge strobe: one cycle in four
  always @(negedge clk) begin
    lp_tick = (tdiv == 3);
    tdiv = (tdiv + 1) % 4;
  end

  // ---------------- behavioural reference model ----------------
  longint m_cnt, m_alm;
  bit m_run, m_seeded, m_busy, m_done, m_err, m_alarm, m_nval, m_viol;
  int m_drain;
  bit [31:0] m_ien;
  int q_addr[$];
  bit [31:0] q_data[$];

  function automatic bit [31:0] m_status();
    return (32'(m_busy) << 10) | (32'(!m_busy) << 9) | (32'(m_done) << 8) |
           (32'(m_err) << 7) | (32'(m_alarm) << 4) | (32'(m_nval) << 1) | 32'(m_viol);
  endfunction

  function automatic bit [31:0] m_read(int a);
    case (a)
      'h00: return 32'(m_cnt >> 15);
      'h04: return 32'(m_cnt & 'h7FFF);
      'h08: return 32'(m_alm >> 15);
      'h0C: return 32'(m_alm & 'h7FFF);
      'h10: return 32'(m_run) << 3;
      'h14: return m_status();
      'h18: return m_ien;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_irq();
    return |(m_status() & m_ien);
  endfunction

  function automatic string req_of(int a);
    case (a)
      'h00, 'h04: return "R8";
      'h08, 'h0C: return "R9";
      'h10: return "R2";
      'h14: return "R3";
      'h18: return "R5";
      default: return "R13";
    endcase
  endfunction

  always @(posedge clk) begin
    bit done, apply, acc, rej, cntwr, step, hit, deferred;
    int pa;
    bit [31:0] pd;
    longint old_alm;
    if (!rst_n) begin
      m_cnt = 0; m_alm = longint'(32'hFFFFFFFF) << 15; m_run = 0; m_seeded = 0;
      m_busy = 0; m_done = 0; m_err = 0; m_alarm = 0; m_nval = 1; m_viol = 0;
      m_drain = 0; m_ien = 0; q_addr.delete(); q_data.delete();
    end else begin
      done     = (m_drain == 1);
      apply    = (q_addr.size() > 0) && lp_tick;
      deferred = (bus_addr <= 5'h14) && (bus_addr[1:0] == 0);
      acc      = bus_wr && deferred && !m_busy;
      rej      = bus_wr && deferred && m_busy;
      pa = -1; pd = 0;
      if (apply) begin pa = q_addr.pop_front(); pd = q_data.pop_front(); end
      cntwr   = apply && (pa == 0 || pa == 4);
      step    = lp_tick && m_run && m_seeded && !m_nval && !cntwr;
      old_alm = m_alm;
      hit     = 0;
      if (step) begin
        m_cnt = (m_cnt + 1) & CMASK;
        if ((old_alm >> 15) != 64'hFFFFFFFF && m_cnt == old_alm) hit = 1;
      end
      case (pa)
        'h00: begin m_cnt = (longint'(pd) << 15) | (m_cnt & 'h7FFF); m_seeded = 1; end
        'h04: m_cnt = (m_cnt & ~longint'('h7FFF)) | (pd & 'h7FFF);
        'h08: m_alm = (longint'(pd) << 15) | (m_alm & 'h7FFF);
        'h0C: m_alm = (m_alm & ~longint'('h7FFF)) | (pd & 'h7FFF);
        'h10: m_run = pd[3];
        'h14: begin
          if (pd[4]) m_alarm = 0;
          if (pd[7]) m_err = 0;
          if (pd[1]) m_nval = 0;
          if (pd[0]) m_viol = 0;
        end
        default: ;
      endcase
      if (hit) m_alarm = 1;
      if (rej) m_err = 1;
      if (tamper) begin m_nval = 1; m_viol = 1; end
      if (done) m_done = 1;
      else if (bus_rd && bus_addr == 5'h14) m_done = 0;
      if (done) m_busy = 0;
      if (acc) begin m_busy = 1; q_addr.push_back(int'(bus_addr)); q_data.push_back(bus_wdata); end
      if (apply) m_drain = SYNC;
      else if (m_drain > 0) m_drain--;
      if (bus_wr && bus_addr == 5'h18) m_ien = bus_wdata & 32'h390;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, after the edge settles
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check(req_of(int'(bus_addr)), bus_rdata, m_read(int'(bus_addr)));
      check("R10", 32'(irq), 32'(m_irq()));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(bit w, bit r, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; tamper = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 5'(rot), 0);
      rot = (rot + 4) % 32;
    end
  endtask

  task automatic peek(logic [4:0] a, output logic [31:0] v);
    cyc(0, 0, a, 0);
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      peek(5'h14, v);
      if (!v[10]) return;
    end
  endtask

  task automatic wr_sync(logic [4:0] a, logic [31:0] d);
    cyc(1, 0, a, d);
    wait_idle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, s, lo;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    peek(5'h00, v); check("R1", v, 0);
    peek(5'h04, v); check("R1", v, 0);
    peek(5'h08, v); check("R1", v, 32'hFFFFFFFF);
    peek(5'h0C, v); check("R1", v, 0);
    peek(5'h10, v); check("R1", v, 0);
    peek(5'h14, v); check("R1", v, 32'h202);
    peek(5'h18, v); check("R1", v, 0);
    check("R1", 32'(irq), 0);
    idle(10);
    // R5 direct enable write
    cyc(1, 0, 5'h18, 32'hFFFF_FFFF);
    peek(5'h18, v); check("R5", v, 32'h390);
    peek(5'h14, v); check("R5", v & 32'h500, 0);
    cyc(1, 0, 5'h18, 32'h100);
    // R3/R12 seconds write
    cyc(1, 0, 5'h00, 32'd5);
    peek(5'h14, v); check("R12", v & 32'h600, 32'h400);
    wait_idle();
    peek(5'h00, v); check("R3", v, 5);
    peek(5'h14, v); check("R3", v & 32'h100, 32'h100);
    check("R10", 32'(irq), 1);
    // R6 status read clears done
    cyc(0, 1, 5'h14, 0);
    peek(5'h14, v); check("R6", v & 32'h100, 0);
    // R8 frozen while not valid and not running
    peek(5'h04, v); idle(20); peek(5'h04, v2); check("R8", v2, v);
    // R7 clear validity flags, then run
    wr_sync(5'h14, 32'h3);
    peek(5'h14, v); check("R7", v & 32'h3, 0);
    wr_sync(5'h10, 32'h8);
    peek(5'h10, v); check("R2", v, 32'h8);
    peek(5'h04, v); idle(39); peek(5'h04, v2); check("R8", v2 - v, 10);
    // R4 write while busy is refused
    cyc(1, 0, 5'h08, 32'd1);
    cyc(1, 0, 5'h0C, 32'h123);
    wait_idle();
    peek(5'h0C, v); check("R4", v, 0);
    peek(5'h14, v); check("R4", v & 32'h80, 32'h80);
    wr_sync(5'h14, 32'h80);
    peek(5'h14, v); check("R7", v & 32'h80, 0);
    // R9 alarm hit
    peek(5'h00, s); peek(5'h04, lo);
    wr_sync(5'h08, s);
    wr_sync(5'h0C, lo + 60);
    cyc(1, 0, 5'h18, 32'h10);
    idle(300);
    peek(5'h14, v); check("R9", v & 32'h10, 32'h10);
    check("R10", 32'(irq), 1);
    wr_sync(5'h14, 32'h10);
    peek(5'h14, v); check("R7", v & 32'h10, 0);
    check("R10", 32'(irq), 0);
    // R9 disarmed alarm and R8 wrap
    wr_sync(5'h08, 32'hFFFFFFFF);
    wr_sync(5'h0C, 32'h7FFA);
    wr_sync(5'h04, 32'h7FF0);
    wr_sync(5'h00, 32'hFFFFFFFF);
    idle(200);
    peek(5'h14, v); check("R9", v & 32'h10, 0);
    peek(5'h00, v); check("R8", v, 0);
    // R11 tamper freezes
    @(negedge clk); tamper = 1;
    peek(5'h14, v); check("R11", v & 32'h3, 32'h3);
    peek(5'h04, v); idle(20); peek(5'h04, v2); check("R11", v2, v);
    // R13 unmapped offset
    cyc(1, 0, 5'h1C, 32'hDEAD);
    peek(5'h1C, v); check("R13", v, 0);
    peek(5'h14, v); check("R13", v & 32'h400, 0);
    idle(20);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule